// File: doc/BRIEF.md
# Banked GPIO Control Register File with Atomic Bit Aliases

This block is the bus-side register file of a multi-port general-purpose I/O controller. Every port serves 32 pins, and each of its control registers holds one bit per pin. Ports sit one after another in the address space at a fixed stride of 0x200 bytes. A global pin number g belongs to port g/32, bit g%32.

Each register takes up a 16-byte slot, and the slot holds four word addresses. A write to the first word replaces the whole register, and a read of any of the four words returns its value. The other three words change only the bits written as one. The second word sets those bits, the third clears them and the fourth inverts them. Software can therefore change single pins without a read-modify-write sequence. Each port has three registers: drive enable (slot 0x00), drive level (slot 0x10) and pin ownership (slot 0x20). Their bits are driven out as flat vectors indexed by global pin number.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register bit and every output vector bit is zero, and a read of any implemented address returns zero.
- R2: A write to offset +0x0 of a register slot replaces all 32 bits with the write data. The change is visible on the outputs and readback starting from the cycle after the accepting clock edge.
- R3: A write to offset +0x4 sets every bit that is one in the write data and leaves every other bit unchanged.
- R4: A write to offset +0x8 clears every bit that is one in the write data and leaves every other bit unchanged.
- R5: A write to offset +0xC inverts every bit that is one in the write data and leaves every other bit unchanged.
- R6: Port p's bank starts at byte address p*0x200. Register slots are at 0x00 (drive enable, `oe_o`), 0x10 (drive level, `lvl_o`) and 0x20 (pin ownership, `own_o`). Bit b of port p appears at output index p*32+b.
- R7: A read at any of the four offsets of a slot returns that register's value combinationally on `rdata`. When `re` is low, `rdata` is zero.
- R8: Accesses to a port number at or above NPORTS, or to a slot offset above 0x2C within a bank, read as zero and change no register.
- R9: A write to one register or port leaves all other registers and ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable, accepted at the clock edge |
| re | input | 1 | Read enable |
| rdata | output | 32 | Read data, combinational |
| oe_o | output | NPORTS*32 | Drive-enable bits, global pin order |
| lvl_o | output | NPORTS*32 | Drive-level bits, global pin order |
| own_o | output | NPORTS*32 | Pin-ownership bits, global pin order |

## Verification
All register state is driven straight to the output vectors, so a bad update shows on the pins one cycle after the write that caused it. A decode fault that hits the wrong register, port or alias changes a bit outside the targeted 32, or changes the wrong bit pattern within them. The bench keeps a full model of every register and compares all three output vectors after each write. A stray change is therefore caught on the next check. A readback fault shows only on `rdata`, so the bench reads every slot offset.

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int NPORTS = 3,
  parameter int AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [31:0]        wdata,
  input  logic               we,
  input  logic               re,
  output logic [31:0]        rdata,
  output logic [NPORTS*32-1:0] oe_o,
  output logic [NPORTS*32-1:0] lvl_o,
  output logic [NPORTS*32-1:0] own_o
);
  localparam int NREG = 3;
  localparam int PW = AW - 9;

  logic [31:0] regs [NPORTS][NREG];
  logic [PW-1:0] port_sel;
  logic [4:0] slot_sel;
  logic [1:0] op;
  logic hit;

  assign port_sel = addr[AW-1:9];
  assign slot_sel = addr[8:4];
  assign op       = addr[3:2];
  assign hit      = (int'(port_sel) < NPORTS) && (int'(slot_sel) < NREG);

  function automatic logic [31:0] apply(input logic [31:0] cur, input logic [31:0] d,
                                        input logic [1:0] kind);
    case (kind)
      2'd0: apply = d;
      2'd1: apply = cur | d;
      2'd2: apply = cur & ~d;
      default: apply = cur ^ d;
    endcase
  endfunction

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[p][r] <= '0;
        else if (we && hit && int'(port_sel) == p && int'(slot_sel) == r)
          regs[p][r] <= apply(regs[p][r], wdata, op);
      end
    end
    assign oe_o[p*32 +: 32]  = regs[p][0];
    assign lvl_o[p*32 +: 32] = regs[p][1];
    assign own_o[p*32 +: 32] = regs[p][2];
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPORTS; p++)
      for (int r = 0; r < NREG; r++)
        if (re && hit && int'(port_sel) == p && int'(slot_sel) == r)
          rdata = regs[p][r];
  end
endmodule

module gpio_regbank_chk #(
  parameter int NPORTS = 3,
  parameter int AW = 12
) (
  input logic clk,
  input logic rst_n,
  input logic [AW-1:0] addr,
  input logic [31:0] wdata,
  input logic we,
  input logic re,
  input logic [31:0] rdata,
  input logic [NPORTS*32-1:0] oe_o,
  input logic [NPORTS*32-1:0] lvl_o,
  input logic [NPORTS*32-1:0] own_o
);
  logic bad_port;
  assign bad_port = int'(addr[AW-1:9]) >= NPORTS;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !re |-> rdata == '0);  // R7
  AST_BADPORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (re && bad_port) |-> rdata == '0);  // R8
  AST_BADPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bad_port) |=> ($stable(oe_o) && $stable(lvl_o) && $stable(own_o)));  // R8
  AST_NOWRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(oe_o) && $stable(lvl_o) && $stable(own_o)));  // R9
  AST_SET_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd1) |=> ((oe_o & $past(oe_o)) == $past(oe_o)));  // R3
  AST_CLR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd2) |=> ((lvl_o | $past(lvl_o)) == $past(lvl_o)));  // R4
endmodule

bind gpio_regbank gpio_regbank_chk #(.NPORTS(NPORTS), .AW(AW)) u_chk (.*);

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
  localparam int NP = 3;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP*32-1:0] oe_o, lvl_o, own_o;
  logic [31:0] m [NP][3];
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_regbank #(.NPORTS(NP), .AW(AW)) u_dut (.*);
  always #10 clk = ~clk;

  function automatic logic [AW-1:0] mk(int p, int s, int o);
    return AW'(p*512 + s*16 + o*4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    int p = int'(a[AW-1:9]); int s = int'(a[8:4]); int o = int'(a[3:2]);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    if (p < NP && s < 3)
      case (o)
        0: m[p][s] = d;
        1: m[p][s] = m[p][s] | d;
        2: m[p][s] = m[p][s] & ~d;
        default: m[p][s] = m[p][s] ^ d;
      endcase
  endtask

  task automatic cmp_all(string req);
    for (int p = 0; p < NP; p++) begin
      chk(req, oe_o[p*32 +: 32], m[p][0]);
      chk(req, lvl_o[p*32 +: 32], m[p][1]);
      chk(req, own_o[p*32 +: 32], m[p][2]);
    end
  endtask

  task automatic rd_all(string req);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 3; s++)
        for (int o = 0; o < 4; o++) begin
          addr = mk(p, s, o); re = 1; #1;
          chk(req, rdata, m[p][s]);
        end
    re = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int s = 0; s < 3; s++) m[p][s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1"); rd_all("R1");
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 3; s++) begin
        wr(mk(p, s, 0), 32'hA5A5_0F0F ^ (p*32'h1111) ^ (s*32'h0101_0000));
        cmp_all("R2 R6 R9");
        wr(mk(p, s, 1), 32'h00FF_00F0 + p);
        cmp_all("R3 R9");
        wr(mk(p, s, 2), 32'h0F0F_F00F << s);
        cmp_all("R4 R9");
        wr(mk(p, s, 3), 32'hFFFF_0000 >> p);
        cmp_all("R5 R9");
        wr(mk(p, s, 3), 32'h0);
        cmp_all("R5");
      end
    rd_all("R7");
    re = 0; addr = mk(0, 1, 0); #1; chk("R7", rdata, 32'h0);
    // global pin 36 -> port 1 bit 4 in drive level
    wr(mk(1, 1, 0), 32'h0); wr(mk(1, 1, 1), 32'h10);
    chk("R6", {31'b0, lvl_o[36]}, 32'h1);
    chk("R6", {31'b0, lvl_o[35]}, 32'h0);
    // unimplemented slots and ports
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 32; s++)
        if (p >= NP || s >= 3)
          for (int o = 0; o < 4; o++) begin
            wr(mk(p, s, o), 32'hFFFF_FFFF);
            addr = mk(p, s, o); re = 1; #1;
            chk("R8", rdata, 32'h0);
            re = 0;
            cmp_all("R8");
          end
    rd_all("R8 R7");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule